// File: doc/BRIEF.md
# Dual-Scan Monochrome LCD Strobe Generator

This block drives the timing strobes of a dual-scan monochrome passive LCD panel with an 8-bit data bus. From a pixel clock it produces a line strobe, a frame strobe, a data shift strobe, an AC-modulation toggle and the byte bus. It pulls one byte at a time from an upstream pixel source through a simple request pin, and each byte carries eight pixels split between the two panel halves. Every time value is counted in pixel-clock cycles.

Four configuration inputs set the line and frame geometry: the display width in units of 8 pixels, the non-display width, the number of lines per frame minus one, and a shift-mask enable. The block copies all four into shadow registers during reset and again at the end of every line. Each line therefore runs on one consistent set of values, even when the inputs change partway through.

Internally the line position is a counter `h` that runs from 0 to P-1 in each line. Here D = (display+1)*16, G = non-display*16 and P = D + G + 64. Each strobe output is registered, so in any cycle it shows the decode of the counter value from the cycle before.

Top module: `lcd_ptgen`

## Requirements
- R1: While `rst` is high, every output (`pix_req`, `lcd_frame`, `lcd_line`, `lcd_shift`, `lcd_mod`, `lcd_data`) is low. A line and a frame start on the first clock after `rst` falls.
- R2: Each line lasts ((display+1)*8 + (non-display+4)*8)*2 pixel clocks. This is the distance between successive rising edges of `lcd_line`.
- R3: During the display part of a line (h < D), `lcd_shift` repeats a 4-clock cycle: high for 2 clocks (h mod 4 in {0,1}), then low for 2 clocks. Its falling edges fall where h mod 4 = 2. The last falling edge of a line is at h = D-2, so one line gives (display+1)*4 falling edges.
- R4: When `cfg_shift_mask` = 1, `lcd_shift` stays low for the whole non-display part (h >= D). When it is 0, the 4-clock cycle keeps running through the non-display part.
- R5: `lcd_line` rises non-display*16 + 20 clocks after the last shift falling edge of the line. It falls 29 clocks after that edge plus non-display*16, so it is high for exactly 9 clocks.
- R6: `pix_req` is high for one cycle at each h < D with h mod 4 = 0. `pix_data` is sampled in that cycle and appears on `lcd_data` on the next clock. `lcd_data` changes at no other time, so each byte is stable for 2 clocks before and 2 clocks after its shift falling edge.
- R7: `lcd_frame` is high for exactly the line with index 0 of every frame. That one full line period contains the falling edge of `lcd_line` for line 0.
- R8: `lcd_mod` toggles once per frame. It changes in the same clock in which `lcd_line` falls during line 0.
- R9: A frame has `cfg_lines`+1 lines. Configuration changes take effect at the next line boundary, never in the middle of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hdisp | input | 7 | Display width in 8-pixel units, minus one |
| cfg_hndp | input | 5 | Non-display width field |
| cfg_lines | input | 10 | Lines per frame minus one |
| cfg_shift_mask | input | 1 | 1 holds the shift strobe low during non-display |
| pix_data | input | 8 | Byte from the pixel source, sampled when `pix_req` is high |
| pix_req | output | 1 | Byte request/accept strobe |
| lcd_frame | output | 1 | Frame strobe |
| lcd_line | output | 1 | Line strobe |
| lcd_shift | output | 1 | Data shift strobe |
| lcd_mod | output | 1 | AC modulation toggle |
| lcd_data | output | 8 | Panel data byte |

## Verification
A wrong horizontal count shows up within one line. It moves the rising edge of `lcd_line` relative to the last shift fall, or it changes the spacing between requests, and the bench model flags this on the very clock where the first edge is off. A wrong vertical count or a missed shadow update stays hidden for up to a full frame. It then appears as a frame strobe that lasts the wrong number of lines, or as an MOD toggle in the wrong line. The bench therefore runs several complete frames for each configuration and changes the configuration in the middle of a frame.

// File: rtl/lcd_ptgen_pkg.sv
package lcd_ptgen_pkg;

    localparam int HDISP_W = 7;
    localparam int HNDP_W  = 5;
    localparam int LINE_W  = 10;
    localparam int DATA_W  = 8;
    localparam int MAX_PERIOD = (1 << HDISP_W) * 16 + ((1 << HNDP_W) - 1) * 16 + 64;
    localparam int HCNT_W  = $clog2(MAX_PERIOD + 1);
    localparam int LP_RISE_OFS = 18;   // after end of display: last fall is 2 before it, +20
    localparam int LP_FALL_OFS = 27;   // last fall +29
    localparam int TAIL_CLKS   = 64;

    typedef logic [HCNT_W-1:0] hcnt_t;

    typedef struct packed {
        logic [HDISP_W-1:0] hdisp;
        logic [HNDP_W-1:0]  hndp;
        logic [LINE_W-1:0]  lines;
        logic               mask;
    } geom_t;

    function automatic hcnt_t disp_len(geom_t g);
        return (hcnt_t'(g.hdisp) + hcnt_t'(1)) << 4;
    endfunction

    function automatic hcnt_t gap_len(geom_t g);
        return hcnt_t'(g.hndp) << 4;
    endfunction

    function automatic hcnt_t line_len(geom_t g);
        return disp_len(g) + gap_len(g) + hcnt_t'(TAIL_CLKS);
    endfunction

    function automatic hcnt_t lp_rise_pt(geom_t g);
        return disp_len(g) + gap_len(g) + hcnt_t'(LP_RISE_OFS);
    endfunction

    function automatic hcnt_t lp_fall_pt(geom_t g);
        return disp_len(g) + gap_len(g) + hcnt_t'(LP_FALL_OFS);
    endfunction

endpackage

// File: rtl/lcd_hcount.sv
module lcd_hcount
    import lcd_ptgen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  geom_t geom_in,
    output hcnt_t hpos,
    output geom_t geom_s,
    output logic  line_end
);

    hcnt_t period;

    assign period   = line_len(geom_s);
    assign line_end = (hpos == period - hcnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos   <= '0;
            geom_s <= geom_in;
        end else if (line_end) begin
            hpos   <= '0;
            geom_s <= geom_in;
        end else begin
            hpos   <= hpos + hcnt_t'(1);
        end
    end

    assert_hpos_range_R2: assert property (@(posedge clk) disable iff (rst)
        hpos < period);

endmodule

// File: rtl/lcd_vcount.sv
module lcd_vcount
    import lcd_ptgen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  hcnt_t hpos,
    input  geom_t geom_s,
    input  logic  line_end,
    output logic  frame_o,
    output logic  mod_o
);

    logic [LINE_W-1:0] vpos;
    logic              first_line;

    assign first_line = (vpos == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            vpos    <= '0;
            frame_o <= 1'b0;
            mod_o   <= 1'b0;
        end else begin
            if (line_end)
                vpos <= (vpos >= geom_s.lines) ? '0 : vpos + 1'b1;
            frame_o <= first_line;
            if (first_line && hpos == lp_fall_pt(geom_s))
                mod_o <= ~mod_o;
        end
    end

    // R8: a modulation change only happens inside the frame strobe
    assert_mod_in_frame_R8: assert property (@(posedge clk) disable iff (rst)
        (mod_o != $past(mod_o)) |-> frame_o);

endmodule

// File: rtl/lcd_strobe.sv
module lcd_strobe
    import lcd_ptgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  hcnt_t             hpos,
    input  geom_t             geom_s,
    input  logic [DATA_W-1:0] pix_data,
    output logic              req_o,
    output logic              shift_o,
    output logic              line_o,
    output logic [DATA_W-1:0] data_o
);

    logic in_disp;
    logic shift_d;
    logic line_d;
    logic [3:0] lp_run;

    assign in_disp = (hpos < disp_len(geom_s));
    assign req_o   = !rst && in_disp && (hpos[1:0] == 2'b00);
    assign shift_d = (geom_s.mask && !in_disp) ? 1'b0 : !hpos[1];
    assign line_d  = (hpos >= lp_rise_pt(geom_s)) && (hpos < lp_fall_pt(geom_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_o <= 1'b0;
            line_o  <= 1'b0;
            data_o  <= '0;
        end else begin
            shift_o <= shift_d;
            line_o  <= line_d;
            if (req_o)
                data_o <= pix_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            lp_run <= '0;
        else if (line_o)
            lp_run <= (lp_run == 4'hf) ? lp_run : lp_run + 4'd1;
        else
            lp_run <= '0;
    end

    assert_line_width_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(line_o) |-> (lp_run == 4'd9));

    assert_mask_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (line_o && geom_s.mask) |-> !shift_o);

    assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(req_o) |-> $stable(data_o));

endmodule

// File: rtl/lcd_ptgen.sv
module lcd_ptgen
    import lcd_ptgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [6:0]  cfg_hdisp,
    input  logic [4:0]  cfg_hndp,
    input  logic [9:0]  cfg_lines,
    input  logic        cfg_shift_mask,
    input  logic [7:0]  pix_data,
    output logic        pix_req,
    output logic        lcd_frame,
    output logic        lcd_line,
    output logic        lcd_shift,
    output logic        lcd_mod,
    output logic [7:0]  lcd_data
);

    geom_t geom_in;
    geom_t geom_s;
    hcnt_t hpos;
    logic  line_end;

    assign geom_in = '{hdisp: cfg_hdisp, hndp: cfg_hndp, lines: cfg_lines, mask: cfg_shift_mask};

    lcd_hcount u_hcount (
        .clk      (clk),
        .rst      (rst),
        .geom_in  (geom_in),
        .hpos     (hpos),
        .geom_s   (geom_s),
        .line_end (line_end)
    );

    lcd_vcount u_vcount (
        .clk      (clk),
        .rst      (rst),
        .hpos     (hpos),
        .geom_s   (geom_s),
        .line_end (line_end),
        .frame_o  (lcd_frame),
        .mod_o    (lcd_mod)
    );

    lcd_strobe u_strobe (
        .clk      (clk),
        .rst      (rst),
        .hpos     (hpos),
        .geom_s   (geom_s),
        .pix_data (pix_data),
        .req_o    (pix_req),
        .shift_o  (lcd_shift),
        .line_o   (lcd_line),
        .data_o   (lcd_data)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !(lcd_frame || lcd_line || lcd_shift || lcd_mod || (lcd_data != 8'h00)));

endmodule

// File: tb/lcd_ptgen_tb_top.sv
`timescale 1ns/1ps
module lcd_ptgen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] cfg_hdisp = 7'd1;
    logic [4:0] cfg_hndp = 5'd0;
    logic [9:0] cfg_lines = 10'd2;
    logic       cfg_shift_mask = 1'b1;
    logic [7:0] pix_data = 8'h00;
    logic       pix_req, lcd_frame, lcd_line, lcd_shift, lcd_mod;
    logic [7:0] lcd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    bit chk_period = 0;

    always #10 clk = ~clk;

    lcd_ptgen dut_i (
        .clk(clk), .rst(rst), .cfg_hdisp(cfg_hdisp), .cfg_hndp(cfg_hndp),
        .cfg_lines(cfg_lines), .cfg_shift_mask(cfg_shift_mask), .pix_data(pix_data),
        .pix_req(pix_req), .lcd_frame(lcd_frame), .lcd_line(lcd_line),
        .lcd_shift(lcd_shift), .lcd_mod(lcd_mod), .lcd_data(lcd_data)
    );

    // reference model state
    int m_h = 0, m_v = 0;
    int s_hd = 0, s_hn = 0, s_ln = 0;
    bit s_mk = 0;
    bit e_shift = 0, e_line = 0, e_frame = 0, e_mod = 0, m_mod = 0;
    logic [7:0] e_data = 8'h00;

    function automatic int disp_of(int hd); return (hd + 1) * 16; endfunction
    function automatic int per_of(int hd, int hn); return ((hd + 1) * 8 + (hn + 4) * 8) * 2; endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_h = 0; m_v = 0; m_mod = 0;
            s_hd = cfg_hdisp; s_hn = cfg_hndp; s_ln = cfg_lines; s_mk = cfg_shift_mask;
            e_shift = 0; e_line = 0; e_frame = 0; e_mod = 0; e_data = 8'h00;
        end else begin
            int last_fall;
            last_fall = disp_of(s_hd) - 2;
            if (m_h >= disp_of(s_hd))
                e_shift = s_mk ? 1'b0 : ((m_h % 4) < 2);
            else
                e_shift = (m_h % 4) < 2;
            e_line = (m_h >= last_fall + s_hn * 16 + 20) && (m_h < last_fall + s_hn * 16 + 29);
            if (m_h < disp_of(s_hd) && (m_h % 4) == 0)
                e_data = pix_data;
            e_frame = (m_v == 0);
            if (m_v == 0 && m_h == last_fall + s_hn * 16 + 29)
                m_mod = !m_mod;
            e_mod = m_mod;
            if (m_h == per_of(s_hd, s_hn) - 1) begin
                m_h = 0;
                m_v = (m_v >= s_ln) ? 0 : m_v + 1;
                s_hd = cfg_hdisp; s_hn = cfg_hndp; s_ln = cfg_lines; s_mk = cfg_shift_mask;
            end else begin
                m_h = m_h + 1;
            end
        end
    end

    // per-clock comparison, plus edge-distance measurements
    int line_rise_prev = -1, line_hi = 0, frame_hi = 0;
    bit line_prev = 0, frame_prev = 0;
    always @(negedge clk) begin
        if (!done) begin
            bit e_req;
            e_req = !rst && (m_h < disp_of(s_hd)) && ((m_h % 4) == 0);
            check("R6 pix_req", pix_req, e_req);
            check(rst ? "R1 reset lcd_shift" : "R3/R4 lcd_shift", lcd_shift, e_shift);
            check(rst ? "R1 reset lcd_line" : "R5 lcd_line", lcd_line, e_line);
            check(rst ? "R1 reset lcd_frame" : "R7 lcd_frame", lcd_frame, e_frame);
            check(rst ? "R1 reset lcd_mod" : "R8 lcd_mod", lcd_mod, e_mod);
            check(rst ? "R1 reset lcd_data" : "R6 lcd_data", lcd_data, e_data);
            if (rst) begin
                line_rise_prev = -1; line_hi = 0; frame_hi = 0;
            end else begin
                if (lcd_line && !line_prev) begin
                    if (chk_period && line_rise_prev >= 0)
                        check("R2 line period", cyc - line_rise_prev, per_of(cfg_hdisp, cfg_hndp));
                    line_rise_prev = cyc;
                end
                if (lcd_line) line_hi++;
                else begin
                    if (line_prev) check("R5 line high width", line_hi, 9);
                    line_hi = 0;
                end
                if (lcd_frame) frame_hi++;
                else begin
                    if (frame_prev && chk_period)
                        check("R7 frame strobe width", frame_hi, per_of(cfg_hdisp, cfg_hndp));
                    frame_hi = 0;
                end
            end
            line_prev = lcd_line;
            frame_prev = lcd_frame;
        end
    end

    // pixel source: a new byte pattern every clock
    initial begin
        forever begin
            @(negedge clk);
            pix_data <= 8'(cyc * 29 + 7);
        end
    end

    task automatic do_reset(int n);
        chk_period = 0;
        @(negedge clk); rst = 1'b1;
        repeat (n) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_cfg(int hd, int hn, int ln, bit mk);
        cfg_hdisp = 7'(hd); cfg_hndp = 5'(hn); cfg_lines = 10'(ln); cfg_shift_mask = mk;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then masked short geometry
        set_cfg(1, 0, 2, 1'b1);
        do_reset(4);
        chk_period = 1;
        repeat (1200) @(negedge clk);
        // R4: unmasked shift, wider non-display, R9 two-line frame
        set_cfg(3, 2, 1, 1'b0);
        do_reset(3);
        chk_period = 1;
        repeat (1500) @(negedge clk);
        // R9: change geometry mid-frame without reset
        chk_period = 0;
        repeat (37) @(negedge clk);
        set_cfg(0, 1, 3, 1'b1);
        repeat (700) @(negedge clk);
        // R2/R7 boundary: minimum widths, single-line frame
        set_cfg(0, 0, 0, 1'b1);
        do_reset(2);
        chk_period = 1;
        repeat (600) @(negedge clk);
        // reset in the middle of a line
        repeat (41) @(negedge clk);
        set_cfg(2, 31, 1, 1'b0);
        do_reset(5);
        chk_period = 1;
        repeat (3000) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule